// File: doc/BRIEF.md
# Ping-Pong Audio Sample Fetcher

This block feeds an audio output stream from two alternating sample buffers held in memory. Software programs two base addresses, one common length in samples, a sample format and four interrupt enables through a small register port, then sets the enable bit. Each one-cycle sample request from the serial side becomes one memory read at the next address of the active buffer. The returned word goes back to the serial side as a sample strobe. When the active buffer runs out, its empty flag is raised and the next request is served from the other buffer with no gap.

Software refills an empty buffer and then writes a one to that buffer's acknowledge bit. The acknowledge clears the empty flag and marks the buffer as full again. If a request finds the active buffer empty, an underrun is flagged and a zero sample is returned. If a request arrives while the previous read is still outstanding, a bandwidth error is flagged. All four flags are sticky, and each is cleared only by its own acknowledge bit. A single level interrupt is high while any flag is set together with its enable.

Top module: `audio_pingpong_dma`

## Requirements
- R1: After reset the block is disabled, buffer A is active, all four flags are 0, and irq, mem_req and smp_valid are 0. The status word reads 0x01.
- R2: Register addresses are 0 control, 1 base A, 2 base B, 3 size and 4 acknowledge (write only). Address 5 is the read-only status word. The base and size registers read back with their six low bits forced to zero. Control bit 0 is enable, bit 1 is stereo, bit 2 is 32-bit width, and bits 4..7 are the interrupt enables in flag order.
- R3: Every accepted request produces exactly one single-cycle mem_req, one cycle later. Its address is the active base plus the byte offset within the buffer. The offset advances by a stride of 2 bytes for 16-bit mono, 4 for 16-bit stereo or 32-bit mono, and 8 for 32-bit stereo.
- R4: The request that takes the last sample of a buffer (size times stride bytes) sets that buffer's empty flag and switches to the other buffer. It also resets the offset to zero, so the next request reads the other base.
- R5: A read response (mem_valid while a read is outstanding) appears one cycle later as smp_valid with smp_data equal to mem_data.
- R6: A request that finds the active buffer empty sets the underrun flag, issues no read, and returns smp_valid with smp_data zero one cycle later. Requests resume from the other buffer's start once that buffer has been acknowledged.
- R7: A request that arrives while a read is outstanding sets the bandwidth-error flag, issues no read, and does not advance the offset.
- R8: While the enable bit is 0, requests produce no read, no sample and no flag change.
- R9: Writing address 4 clears each flag whose bit is 1: bit 0 clears empty A, bit 1 clears empty B, bit 2 clears bandwidth error, bit 3 clears underrun. The flag is 0 after the very next clock edge. Bits written as 0 leave their flags alone. A flag that is set in the same cycle as its acknowledge stays set.
- R10: irq is high exactly while some flag and its enable bit are both 1.
- R11: Status bit 0 is the active-buffer bit (1 means A). Bits 1..4 are empty A, empty B, bandwidth error and underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DW | Register read data (combinational) |
| smp_req | input | 1 | One-cycle sample request from the serial side |
| smp_valid | output | 1 | Sample strobe to the serial side |
| smp_data | output | DW | Sample word |
| mem_req | output | 1 | Memory read request pulse |
| mem_addr | output | AW | Memory byte address |
| mem_valid | input | 1 | Memory read data valid |
| mem_data | input | DW | Memory read data |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle, assertions check the following. Acknowledges clear flags on the next edge, and unacknowledged flags hold. A raised empty-A flag coincides with buffer B becoming active. A request that arrives while a read is outstanding, or while the block is disabled, never yields a read pulse. Every read pulse lasts one cycle, and irq stays low when all enables are clear. Only the bench scenarios can show the rest. That covers the address sequence across all four formats, the seamless handoff between buffers, the zero sample and automatic resume after underrun, the unchanged offset after a dropped late request, and the rule that a set beats a clear in the same cycle.

// File: rtl/ppdma_pkg.sv
`timescale 1ns/1ps
package ppdma_pkg;
  typedef enum logic [2:0] {
    RA_CTRL   = 3'd0,
    RA_BASE_A = 3'd1,
    RA_BASE_B = 3'd2,
    RA_SIZE   = 3'd3,
    RA_ACK    = 3'd4,
    RA_STAT   = 3'd5
  } reg_addr_e;

  localparam int NFLAG      = 4;
  localparam int FL_EMPTY_A = 0;
  localparam int FL_EMPTY_B = 1;
  localparam int FL_BW      = 2;
  localparam int FL_UDR     = 3;
  localparam int ALIGN      = 6;

  typedef struct packed {
    logic wide;
    logic stereo;
  } fmt_t;

  // log2 of bytes per sample slot: 16-bit mono = 1, ... 32-bit stereo = 3
  function automatic logic [1:0] stride_shift(input fmt_t f);
    return 2'd1 + {1'b0, f.wide} + {1'b0, f.stereo};
  endfunction
endpackage

// File: rtl/ppdma_regs.sv
`timescale 1ns/1ps
module ppdma_regs
  import ppdma_pkg::*;
#(
  parameter int AW  = 16,
  parameter int SZW = 12,
  parameter int DW  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [NFLAG-1:0] set_ev,
  output logic             enable,
  output fmt_t             fmt,
  output logic [NFLAG-1:0] ien,
  output logic [AW-1:0]    base_a,
  output logic [AW-1:0]    base_b,
  output logic [SZW-1:0]   size_smp,
  output logic [NFLAG-1:0] flags
);
  logic                  en_q, en_d;
  fmt_t                  fmt_q, fmt_d;
  logic [NFLAG-1:0]      ien_q, ien_d;
  logic [NFLAG-1:0]      flg_q, flg_d;
  logic [NFLAG-1:0]      ack_v;
  logic [AW-ALIGN-1:0]   ba_q, ba_d, bb_q, bb_d;
  logic [SZW-ALIGN-1:0]  sz_q, sz_d;
  logic                  unused_wr;

  assign unused_wr = ^wr_data;

  always_comb begin
    en_d  = en_q;
    fmt_d = fmt_q;
    ien_d = ien_q;
    ba_d  = ba_q;
    bb_d  = bb_q;
    sz_d  = sz_q;
    ack_v = '0;
    if (wr_en) begin
      case (wr_addr)
        RA_CTRL: begin
          en_d  = wr_data[0];
          fmt_d = fmt_t'(wr_data[2:1]);
          ien_d = wr_data[4 +: NFLAG];
        end
        RA_BASE_A: ba_d  = wr_data[AW-1:ALIGN];
        RA_BASE_B: bb_d  = wr_data[AW-1:ALIGN];
        RA_SIZE:   sz_d  = wr_data[SZW-1:ALIGN];
        RA_ACK:    ack_v = wr_data[NFLAG-1:0];
        default:   ;
      endcase
    end
    // a new event outranks a clear in the same cycle
    flg_d = set_ev | (flg_q & ~ack_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      fmt_q <= '0;
      ien_q <= '0;
      ba_q  <= '0;
      bb_q  <= '0;
      sz_q  <= '0;
      flg_q <= '0;
    end else begin
      en_q  <= en_d;
      fmt_q <= fmt_d;
      ien_q <= ien_d;
      ba_q  <= ba_d;
      bb_q  <= bb_d;
      sz_q  <= sz_d;
      flg_q <= flg_d;
    end
  end

  assign enable   = en_q;
  assign fmt      = fmt_q;
  assign ien      = ien_q;
  assign base_a   = {ba_q, {ALIGN{1'b0}}};
  assign base_b   = {bb_q, {ALIGN{1'b0}}};
  assign size_smp = {sz_q, {ALIGN{1'b0}}};
  assign flags    = flg_q;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag_chk
    // R9: acknowledge without a competing event clears on the next edge
    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_v[i] && !set_ev[i]) |=> !flg_q[i]);
    // R9: a flag stays set until its own acknowledge
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flg_q[i] && !ack_v[i]) |=> flg_q[i]);
  end
endmodule

// File: rtl/ppdma_seq.sv
`timescale 1ns/1ps
module ppdma_seq
  import ppdma_pkg::*;
#(
  parameter int AW  = 16,
  parameter int SZW = 12,
  parameter int DW  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  fmt_t             fmt,
  input  logic [AW-1:0]    base_a,
  input  logic [AW-1:0]    base_b,
  input  logic [SZW-1:0]   size_smp,
  input  logic             empty_a,
  input  logic             empty_b,
  input  logic             smp_req,
  input  logic             mem_valid,
  input  logic [DW-1:0]    mem_data,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  output logic             smp_valid,
  output logic [DW-1:0]    smp_data,
  output logic             active_a,
  output logic [NFLAG-1:0] set_ev
);
  localparam int OW = SZW + 3;

  logic            busy_q, busy_d;
  logic            act_q, act_d;
  logic            mreq_q, mreq_d;
  logic [AW-1:0]   maddr_q, maddr_d;
  logic            sval_q, sval_d;
  logic [DW-1:0]   sdat_q, sdat_d;
  logic [OW-1:0]   off_q, off_d;

  logic [1:0]      shift;
  logic [OW-1:0]   step, size_b, off_nx;
  logic            last, take, issue, starve, late, act_emp;
  logic [AW-1:0]   act_base;

  always_comb begin
    shift    = stride_shift(fmt);
    step     = OW'(1) << shift;
    size_b   = OW'(size_smp) << shift;
    off_nx   = off_q + step;
    last     = off_nx >= size_b;
    act_base = act_q ? base_a : base_b;
    act_emp  = act_q ? empty_a : empty_b;
    take     = smp_req && enable;
    issue    = take && !busy_q && !act_emp;
    starve   = take && !busy_q && act_emp;
    late     = take && busy_q;

    set_ev         = '0;
    set_ev[FL_BW]  = late;
    set_ev[FL_UDR] = starve;
    if (issue && last) begin
      if (act_q) set_ev[FL_EMPTY_A] = 1'b1;
      else       set_ev[FL_EMPTY_B] = 1'b1;
    end

    busy_d  = busy_q;
    act_d   = act_q;
    off_d   = off_q;
    mreq_d  = 1'b0;
    maddr_d = maddr_q;
    sval_d  = 1'b0;
    sdat_d  = sdat_q;

    if (issue) begin
      mreq_d  = 1'b1;
      maddr_d = act_base + AW'(off_q);
      busy_d  = 1'b1;
      if (last) begin
        off_d = '0;
        act_d = !act_q;
      end else begin
        off_d = off_nx;
      end
    end
    if (busy_q && mem_valid) begin
      busy_d = 1'b0;
      sval_d = 1'b1;
      sdat_d = mem_data;
    end
    if (starve) begin
      sval_d = 1'b1;
      sdat_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      act_q   <= 1'b1;
      off_q   <= '0;
      mreq_q  <= 1'b0;
      maddr_q <= '0;
      sval_q  <= 1'b0;
      sdat_q  <= '0;
    end else begin
      busy_q  <= busy_d;
      act_q   <= act_d;
      off_q   <= off_d;
      mreq_q  <= mreq_d;
      maddr_q <= maddr_d;
      sval_q  <= sval_d;
      sdat_q  <= sdat_d;
    end
  end

  assign mem_req   = mreq_q;
  assign mem_addr  = maddr_q;
  assign smp_valid = sval_q;
  assign smp_data  = sdat_q;
  assign active_a  = act_q;

  // R7: a request during an outstanding read never issues another read
  p_no_read_when_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && smp_req) |=> !mem_req);
  // R8: disabled requests stay silent on the memory side
  p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && smp_req) |=> !mem_req);
  // R3: read request is a single-cycle pulse
  p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
endmodule

// File: rtl/audio_pingpong_dma.sv
`timescale 1ns/1ps
module audio_pingpong_dma
  import ppdma_pkg::*;
#(
  parameter int AW  = 16,
  parameter int SZW = 12,
  parameter int DW  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [2:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          smp_req,
  output logic          smp_valid,
  output logic [DW-1:0] smp_data,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_valid,
  input  logic [DW-1:0] mem_data,
  output logic          irq
);
  logic             enable, active_a;
  fmt_t             fmt;
  logic [NFLAG-1:0] ien, flags, set_ev;
  logic [AW-1:0]    base_a, base_b;
  logic [SZW-1:0]   size_smp;

  ppdma_regs #(.AW(AW), .SZW(SZW), .DW(DW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .set_ev   (set_ev),
    .enable   (enable),
    .fmt      (fmt),
    .ien      (ien),
    .base_a   (base_a),
    .base_b   (base_b),
    .size_smp (size_smp),
    .flags    (flags)
  );

  ppdma_seq #(.AW(AW), .SZW(SZW), .DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .fmt       (fmt),
    .base_a    (base_a),
    .base_b    (base_b),
    .size_smp  (size_smp),
    .empty_a   (flags[FL_EMPTY_A]),
    .empty_b   (flags[FL_EMPTY_B]),
    .smp_req   (smp_req),
    .mem_valid (mem_valid),
    .mem_data  (mem_data),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .active_a  (active_a),
    .set_ev    (set_ev)
  );

  assign irq = |(flags & ien);

  always_comb begin
    case (rd_addr)
      RA_CTRL:   rd_data = DW'({ien, 1'b0, fmt, enable});
      RA_BASE_A: rd_data = DW'(base_a);
      RA_BASE_B: rd_data = DW'(base_b);
      RA_SIZE:   rd_data = DW'(size_smp);
      RA_STAT:   rd_data = DW'({flags, active_a});
      default:   rd_data = '0;
    endcase
  end

  // R4: buffer A reports empty exactly as buffer B takes over
  p_switch_on_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[FL_EMPTY_A]) |-> !active_a);
  // R10: no enable, no interrupt
  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);
endmodule

// File: tb/sim_audio_pingpong_dma.sv
`timescale 1ns/1ps
module sim_audio_pingpong_dma;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam logic [15:0] BA = 16'h1000;
  localparam logic [15:0] BB = 16'h2400;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [2:0]    wr_addr;
  logic [DW-1:0] wr_data;
  logic [2:0]    rd_addr;
  logic [DW-1:0] rd_data;
  logic          smp_req, smp_valid, mem_req, mem_valid, irq;
  logic [DW-1:0] smp_data, mem_data;
  logic [AW-1:0] mem_addr;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  audio_pingpong_dma u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .smp_req(smp_req), .smp_valid(smp_valid),
    .smp_data(smp_data), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_data(mem_data), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = 3'd5;
    smp_req = 1'b0; mem_valid = 1'b0; mem_data = '0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic stat_is(input string tag, input logic [31:0] exp);
    logic [31:0] v;
    rd(3'd5, v);
    chk(tag, v, exp);
  endtask

  function automatic logic [31:0] word_of(input logic [15:0] a);
    return {~a, a};
  endfunction

  // one full request: read pulse, response, sample strobe
  task automatic sample(input logic [15:0] exp_addr);
    smp_req = 1'b1;
    tick();
    smp_req = 1'b0;
    chk("R3 mem_req pulse", {31'd0, mem_req}, 32'd1);
    chk("R3 read address", {16'd0, mem_addr}, {16'd0, exp_addr});
    mem_valid = 1'b1;
    mem_data  = word_of(mem_addr);
    tick();
    mem_valid = 1'b0;
    chk("R3 pulse ends", {31'd0, mem_req}, 32'd0);
    chk("R5 smp_valid", {31'd0, smp_valid}, 32'd1);
    chk("R5 smp_data", smp_data, word_of(exp_addr));
  endtask

  // status bits: 0 active A, 1 empty A, 2 empty B, 3 bw, 4 underrun
  task automatic run_fmt(input int f);
    int st;
    logic [31:0] v;
    st = 2 << ((f & 1) + ((f >> 1) & 1));
    do_reset();
    wr(3'd1, {16'd0, BA});
    wr(3'd2, {16'd0, BB});
    wr(3'd3, 32'd64);
    wr(3'd0, 32'hF1 | (f << 1));
    for (int k = 0; k < 64; k++) sample(BA + 16'(k * st));
    stat_is("R4 A empty, B active", 32'h02);
    chk("R10 irq on empty A", {31'd0, irq}, 32'd1);
    wr(3'd4, 32'h1);
    stat_is("R9 ack A clears", 32'h00);
    chk("R9 irq drops after ack", {31'd0, irq}, 32'd0);
    for (int k = 0; k < 64; k++) sample(BB + 16'(k * st));
    stat_is("R4 B empty, A active", 32'h05);
    for (int k = 0; k < 64; k++) sample(BA + 16'(k * st));
    stat_is("R11 both empty, B active", 32'h06);
    smp_req = 1'b1;
    tick();
    smp_req = 1'b0;
    chk("R6 no read on underrun", {31'd0, mem_req}, 32'd0);
    chk("R6 zero sample strobe", {31'd0, smp_valid}, 32'd1);
    chk("R6 zero sample data", smp_data, 32'd0);
    stat_is("R6 underrun flag", 32'h16);
    wr(3'd4, 32'h2);
    stat_is("R9 ack B leaves underrun", 32'h12);
    chk("R10 irq held by underrun", {31'd0, irq}, 32'd1);
    wr(3'd4, 32'h8);
    stat_is("R9 ack underrun", 32'h02);
    sample(BB);
    rd(3'd0, v);
    chk("R2 control readback", v, 32'hF1 | (f << 1));
  endtask

  initial begin
    logic [31:0] v;
    do_reset();
    // R1
    stat_is("R1 reset status", 32'h01);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R1 smp_valid", {31'd0, smp_valid}, 32'd0);
    // R2
    wr(3'd1, 32'h0001_237F);
    rd(3'd1, v); chk("R2 base A aligned", v, 32'h2340);
    wr(3'd2, 32'h0000_FFFF);
    rd(3'd2, v); chk("R2 base B aligned", v, 32'hFFC0);
    wr(3'd3, 32'h0000_0FFF);
    rd(3'd3, v); chk("R2 size aligned", v, 32'h0FC0);
    // R8: disabled requests
    wr(3'd0, 32'hF0);
    smp_req = 1'b1; tick(); smp_req = 1'b0;
    chk("R8 no read", {31'd0, mem_req}, 32'd0);
    chk("R8 no sample", {31'd0, smp_valid}, 32'd0);
    stat_is("R8 flags untouched", 32'h01);
    // R7: late request
    wr(3'd1, {16'd0, BA});
    wr(3'd3, 32'd64);
    wr(3'd0, 32'h41);
    smp_req = 1'b1; tick();
    chk("R7 first read", {31'd0, mem_req}, 32'd1);
    tick(); smp_req = 1'b0;
    chk("R7 no second read", {31'd0, mem_req}, 32'd0);
    stat_is("R7 bw flag", 32'h09);
    chk("R10 irq on bw", {31'd0, irq}, 32'd1);
    mem_valid = 1'b1; mem_data = word_of(BA); tick(); mem_valid = 1'b0;
    chk("R5 late data delivered", smp_data, word_of(BA));
    wr(3'd4, 32'h4);
    stat_is("R9 ack bw", 32'h01);
    sample(BA + 16'd2);
    // R9 set beats clear, R10 masked
    do_reset();
    wr(3'd1, {16'd0, BA});
    wr(3'd3, 32'd64);
    wr(3'd0, 32'h01);
    for (int k = 0; k < 63; k++) sample(BA + 16'(k * 2));
    smp_req = 1'b1; wr_en = 1'b1; wr_addr = 3'd4; wr_data = 32'h1;
    tick();
    smp_req = 1'b0; wr_en = 1'b0;
    stat_is("R9 set wins over ack", 32'h02);
    chk("R10 masked irq", {31'd0, irq}, 32'd0);
    mem_valid = 1'b1; mem_data = 32'd0; tick(); mem_valid = 1'b0;
    // full sweeps over every format
    for (int f = 0; f < 4; f++) run_fmt(f);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule